// File: doc/BRIEF.md
# TDM codec link framer

This block runs the serial link to an audio codec that carries one frame of sixteen 16-bit slots every 256 bit periods, sending and receiving at the same time. It makes the frame sync itself by counting bit periods. Each slot is shifted most significant bit first. In the usual use, slot 0 carries the tag, slots 1 and 2 carry the command or status address and data, and slots 3 and 4 carry the left and right samples. The framer does not decode these slots; it moves whole frames.

Software or a sequencer writes transmit words into a bank of slot registers at any time. At each frame boundary the whole bank is copied into the outgoing frame in one step, so a word written during frame N goes out in frame N+1. Received bits are collected across the frame. When the last bit of slot 15 arrives, all sixteen words are latched into the receive bank together and a one-cycle `frame_done` pulse is raised. The bank then holds those words for the whole of the next frame.

The `clk` input is the codec bit clock, connected inverted, so that every rising edge of `clk` is a falling edge of the bit clock. Serial data is launched and sampled on that edge. With a 12.288 MHz bit clock the frame rate is 48 kHz. The write port has no back-pressure: a write is taken on every edge where `tx_wr_en` is high, and the data path is fixed by the frame timing. For that reason the ports are plain and use no handshake.

Top module: `tdm_codec_link`

## Requirements
- R1: While `rst_n` is low, `sdo`, `fsync` and `frame_done` are 0, `rx_slots` is all zeros, and the transmit bank is cleared.
- R2: `fsync` is high for exactly one `clk` cycle in every 256, so the sync period is 16 slots × 16 bits.
- R3: `fsync` is high during the bit period just before the first bit of slot 0, which is the period that carries the last bit of slot 15. The first `fsync` comes one cycle after reset is released.
- R4: In every frame, slot k goes out on `sdo` during bit periods 16k to 16k+15 of the frame, most significant bit first.
- R5: A transmit word written with `tx_wr_en` (slot number on `tx_wr_slot`, word on `tx_wr_data`) appears only in frames that start after the write. A write on the edge that starts a frame applies to the following frame. No frame mixes words from two bank states.
- R6: The bit on `sdi` in bit period 16k+j of a frame (j = 0 for the MSB) lands in bit 15-j of `rx_slots[16k +: 16]`. All sixteen words update together on the edge after the frame's last bit and then hold for the whole next frame.
- R7: `frame_done` pulses high for one cycle, once per frame, in the first cycle in which `rx_slots` shows the new frame. No pulse follows the partial frame in progress when reset is released.
- R8: Slots that have never been written since reset are sent as zeros. The first frame after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted codec bit clock; its rising edge is the bit clock's falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from the codec |
| sdo | output | 1 | Serial data to the codec |
| fsync | output | 1 | Active-high frame sync, one bit period early |
| tx_wr_en | input | 1 | Write strobe for the transmit slot bank |
| tx_wr_slot | input | 4 | Slot number to write |
| tx_wr_data | input | 16 | Word for that slot |
| rx_slots | output | 256 | Received frame; slot k at bits [16k+15:16k] |
| frame_done | output | 1 | One-cycle pulse when a new received frame is latched |

## Verification
Each frame uses a different transmit and receive pattern, in this order: all zeros, all ones, a walking one whose position follows the slot number, alternating 0xAAAA/0x5555 words, and an arithmetic mix that gives every slot a unique word. The walking one and the unique words expose swapped slots and a bit order that is reversed. All ones and all zeros expose stuck or shifted data. The bench rewrites the bank while each frame is being sent, and once per frame it writes on the exact edge that starts a frame, which shows whether the copy at the boundary is atomic. The first frames after reset check the zero-filled bank and that no `frame_done` pulse follows the partial first frame.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  localparam int DEF_SLOTS  = 16;
  localparam int DEF_WORD_W = 16;

  function automatic int pos_width(input int frame_len);
    return (frame_len > 2) ? $clog2(frame_len) : 1;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int FRAME_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_last,
  output logic fsync
);
  localparam int POS_W = tdm_link_pkg::pos_width(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] PRE_POS  = POS_W'(FRAME_LEN - 2);

  logic [POS_W-1:0] pos_q;

  assign frame_last = (pos_q == LAST_POS);

  // pos_q is the frame bit now on the serial lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= PRE_POS;
      fsync <= 1'b0;
    end else begin
      pos_q <= frame_last ? '0 : pos_q + 1'b1;
      fsync <= (pos_q == PRE_POS);
    end
  end
endmodule

// File: rtl/tdm_tx_bank.sv
module tdm_tx_bank #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     load,
  output logic                     sdo
);
  localparam int FRAME_LEN = SLOTS * WORD_W;
  localparam int SLOT_AW   = $clog2(SLOTS);

  logic [SLOTS-1:0][WORD_W-1:0] bank_q;
  logic [FRAME_LEN-1:0]         flat;
  logic [FRAME_LEN-1:0]         shift_q;

  // slot 0 sits at the top so it leaves first
  for (genvar k = 0; k < SLOTS; k++) begin : g_flat
    assign flat[(SLOTS-1-k)*WORD_W +: WORD_W] = bank_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (wr_en && (wr_slot == SLOT_AW'(k))) bank_q[k] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shift_q <= '0;
    else if (load) shift_q <= flat;
    else           shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
  end

  assign sdo = shift_q[FRAME_LEN-1];
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sdi,
  input  logic                      frame_last,
  output logic [SLOTS*WORD_W-1:0]   rx_slots,
  output logic                      frame_done
);
  localparam int FRAME_LEN = SLOTS * WORD_W;

  logic [FRAME_LEN-2:0] shift_q;
  logic [FRAME_LEN-1:0] full;
  logic [FRAME_LEN-1:0] remap;
  logic                 armed_q;

  assign full = {shift_q, sdi};

  // first-received word is at the top of full; slot k goes to low-order lane k
  for (genvar k = 0; k < SLOTS; k++) begin : g_remap
    assign remap[k*WORD_W +: WORD_W] = full[(SLOTS-1-k)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      rx_slots   <= '0;
      armed_q    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      shift_q    <= {shift_q[FRAME_LEN-3:0], sdi};
      frame_done <= frame_last && armed_q;
      if (frame_last) begin
        armed_q <= 1'b1;
        if (armed_q) rx_slots <= remap;
      end
    end
  end
endmodule

// File: rtl/tdm_codec_link.sv
module tdm_codec_link #(
  parameter int SLOTS  = tdm_link_pkg::DEF_SLOTS,
  parameter int WORD_W = tdm_link_pkg::DEF_WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     fsync,
  input  logic                     tx_wr_en,
  input  logic [$clog2(SLOTS)-1:0] tx_wr_slot,
  input  logic [WORD_W-1:0]        tx_wr_data,
  output logic [SLOTS*WORD_W-1:0]  rx_slots,
  output logic                     frame_done
);
  localparam int FRAME_LEN = SLOTS * WORD_W;

  logic frame_last;

  tdm_frame_timer #(.FRAME_LEN(FRAME_LEN)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_last (frame_last),
    .fsync      (fsync)
  );

  tdm_tx_bank #(.SLOTS(SLOTS), .WORD_W(WORD_W)) tx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_wr_en),
    .wr_slot (tx_wr_slot),
    .wr_data (tx_wr_data),
    .load    (frame_last),
    .sdo     (sdo)
  );

  tdm_rx_capture #(.SLOTS(SLOTS), .WORD_W(WORD_W)) rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdi        (sdi),
    .frame_last (frame_last),
    .rx_slots   (rx_slots),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/tdm_codec_link_chk.sv
module tdm_codec_link_chk #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sdo,
  input logic                    fsync,
  input logic                    frame_done,
  input logic [SLOTS*WORD_W-1:0] rx_slots
);
  localparam int FRAME_LEN = SLOTS * WORD_W;

  int  gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (fsync) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sdo && !fsync && !frame_done && rx_slots == '0));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync);

  // R2
  sync_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && seen_q) |-> (gap_q == FRAME_LEN - 1));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(fsync));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(rx_slots));
endmodule

bind tdm_codec_link tdm_codec_link_chk #(.SLOTS(SLOTS), .WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdo        (sdo),
  .fsync      (fsync),
  .frame_done (frame_done),
  .rx_slots   (rx_slots)
);

// File: tb/tdm_codec_link_tb_top.sv
module tdm_codec_link_tb_top;
  localparam int CLK_P  = 10;
  localparam int NFRAME = 14;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sdi;
  logic         tx_wr_en;
  logic [3:0]   tx_wr_slot;
  logic [15:0]  tx_wr_data;
  logic         sdo;
  logic         fsync;
  logic         frame_done;
  logic [255:0] rx_slots;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tdm_codec_link dut_i (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo), .fsync(fsync),
    .tx_wr_en(tx_wr_en), .tx_wr_slot(tx_wr_slot), .tx_wr_data(tx_wr_data),
    .rx_slots(rx_slots), .frame_done(frame_done)
  );

  function automatic logic [15:0] tx_pat(input int f, input int k);
    case (f % 5)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001 << k;
      3: return (k % 2 == 1) ? 16'hAAAA : 16'h5555;
      default: return (16'(k) * 16'h1357 + 16'(f) * 16'h0F0F) ^ 16'hC3A5;
    endcase
  endfunction

  function automatic logic [15:0] rx_pat(input int f, input int k);
    return tx_pat(f + 2, 15 - k) ^ {4{4'(k)}};
  endfunction

  function automatic logic [255:0] rx_frame(input int f);
    logic [255:0] v;
    for (int k = 0; k < 16; k++) v[k*16 +: 16] = rx_pat(f, k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  logic [15:0]  mbank [16];
  logic [15:0]  exp_tx [16];
  logic [15:0]  got;
  logic [15:0]  w;
  logic [255:0] last_rx;
  int bpos, fr, nb, gap, skip_slot, done_bad, k;
  bit seen_fs, tx_active;

  initial begin
    rst_n = 1'b0; sdi = 1'b0; tx_wr_en = 1'b0; tx_wr_slot = '0; tx_wr_data = '0;
    bpos = -1; fr = -1; gap = 0; skip_slot = -1; done_bad = 0;
    seen_fs = 1'b0; tx_active = 1'b0; got = '0; last_rx = '0;
    for (int i = 0; i < 16; i++) mbank[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R1 sdo", 256'(sdo), 256'd0);
    chk(fsync == 1'b0, "R1 fsync", 256'(fsync), 256'd0);
    chk(frame_done == 1'b0, "R1 frame_done", 256'(frame_done), 256'd0);
    chk(rx_slots == '0, "R1 rx_slots", rx_slots, 256'd0);
    rst_n = 1'b1;
    chk(fsync == 1'b0, "R3 no sync before first edge", 256'(fsync), 256'd0);

    for (int cyc = 0; cyc < NFRAME * 256 + 4; cyc++) begin
      @(negedge clk);
      // position tracking, R2 and R3
      nb = (bpos >= 0) ? (bpos + 1) % 256 : -1;
      if (fsync) begin
        if (nb >= 0) chk(nb == 255, "R3 sync position", 256'(nb), 256'd255);
        else chk(cyc == 0, "R3 first sync", 256'(cyc), 256'd0);
        if (seen_fs) chk(gap == 255, "R2 sync period", 256'(gap), 256'd255);
        seen_fs = 1'b1;
        gap = 0;
        bpos = 255;
      end else begin
        gap++;
        bpos = nb;
      end
      if (bpos == 0) fr++;

      // transmit words, R3 R4 R5 R8
      if (tx_active && bpos >= 0) begin
        got = {got[14:0], sdo};
        if (bpos % 16 == 15) begin
          k = bpos / 16;
          chk(got == exp_tx[k],
              (k == 0) ? "R3 slot0 alignment" : (fr == 0 ? "R8 zero bank" : "R4/R5 slot word"),
              256'(got), 256'(exp_tx[k]));
        end
      end
      if (fsync) begin
        for (int i = 0; i < 16; i++) exp_tx[i] = mbank[i];
        tx_active = 1'b1;
      end

      // receive frame, R6 R7
      if (bpos >= 0 && fr >= 0) begin
        if (bpos == 0) begin
          if (fr >= 1) begin
            chk(frame_done == 1'b1, "R7 pulse", 256'(frame_done), 256'd1);
            last_rx = rx_frame(fr - 1);
            chk(rx_slots == last_rx, "R6 captured frame", rx_slots, last_rx);
          end else begin
            chk(frame_done == 1'b0, "R7 no pulse after partial frame", 256'(frame_done), 256'd0);
          end
        end else if (frame_done) begin
          done_bad++;
        end
        if (bpos == 128 && fr >= 1)
          chk(rx_slots == last_rx, "R6 hold", rx_slots, last_rx);
        if (bpos == 255) begin
          chk(done_bad == 0, "R7 single pulse", 256'(done_bad), 256'd0);
          done_bad = 0;
        end
        w = rx_pat(fr, bpos / 16);
        sdi = w[15 - bpos % 16];
      end else begin
        sdi = 1'b0;
      end

      // bank writes for the next frame, R5
      tx_wr_en = 1'b0;
      if (bpos >= 0 && fr >= 0) begin
        if (bpos == 255) begin
          k = fr % 16;
          tx_wr_en = 1'b1; tx_wr_slot = 4'(k); tx_wr_data = ~tx_pat(fr + 1, k);
          mbank[k] = tx_wr_data;
          skip_slot = k;
        end else if (bpos >= 7 && (bpos - 7) % 15 == 0 && (bpos - 7) / 15 < 16) begin
          k = (bpos - 7) / 15;
          if (k != skip_slot) begin
            tx_wr_en = 1'b1; tx_wr_slot = 4'(k); tx_wr_data = tx_pat(fr + 1, k);
            mbank[k] = tx_wr_data;
          end
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule